// File: doc/BRIEF.md
# Pending Interrupt Queue with Class-Range Purge

This block keeps a small set of pending interrupt entries in a register array that is already ordered by priority. Slot 0 holds the lowest-priority entry and slot `count-1` holds the highest, which is the top. Each entry has a class code and a payload. The surrounding logic decides where an entry belongs in the order, so a push always lands just above the current top.

A consumer takes the top entry from the top port and then pops it. For example, an external interrupt that has been serviced is removed by a pop, which lowers the count by one. The purge request removes one contiguous run of entries in a single clock. The run starts at the lowest slot whose class is at or above a low bound. It ends at the highest slot, at or above that start, whose class is at or below a high bound. The surviving higher-priority entries then slide down to close the gap, keeping their order.

Top module: `irq_class_queue`

## Requirements
- R1: After reset `count` is 0, `topValid` is 0 and `overflow` is 0.
- R2: A push that is accepted when no pop is taken writes the entry into slot `count`, and `count` rises by one at the next clock.
- R3: The top port shows the class and payload of slot `count-1`, and `topValid` is high when `count` is not 0. A pop removes that entry and lowers `count` by one. A pop while `count` is 0 has no effect.
- R4: A push and a pop in the same cycle on a non-empty queue replace the top entry with the pushed entry, and `count` does not change. This also works when the queue is full.
- R5: A push that would exceed the depth, with no pop taken, is refused. The contents and `count` are unchanged, and `overflow` is high for exactly the one cycle after the refused push.
- R6: A purge begins at the lowest occupied slot whose class is greater than or equal to `purgeLo`. If there is no such slot, nothing is removed.
- R7: A purge ends at the highest occupied slot, not below its start, whose class is less than or equal to `purgeHi`. If there is no such slot, nothing is removed.
- R8: After a purge, the entries above the removed run appear in their original order starting at the start slot. `count` drops by the length of the run. All of this happens at the clock edge that takes the purge.
- R9: `busy` equals `purgeReq` in the same cycle. A push or pop presented while `busy` is high is ignored and does not raise `overflow`.
- R10: `rdClass` and `rdData` combinationally show the entry held in slot `rdIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushClass | input | CLS_W | Class of the pushed entry |
| pushData | input | DATA_W | Payload of the pushed entry |
| popReq | input | 1 | Pop the top entry |
| purgeReq | input | 1 | Purge request |
| purgeLo | input | CLS_W | Low class bound of the purge |
| purgeHi | input | CLS_W | High class bound of the purge |
| rdIdx | input | IDX_W | Slot selected for reading |
| count | output | CNT_W | Number of occupied slots |
| topValid | output | 1 | Queue is not empty |
| topClass | output | CLS_W | Class of the top entry |
| topData | output | DATA_W | Payload of the top entry |
| rdClass | output | CLS_W | Class in slot `rdIdx` |
| rdData | output | DATA_W | Payload in slot `rdIdx` |
| busy | output | 1 | Purge in progress; push and pop are stalled |
| overflow | output | 1 | One-cycle flag after a refused push |

## Verification
`busy` is combinational, so the bench samples it in the same cycle as the request, while the inputs are still held. Contents, `count` and the top port change at the one clock edge that takes a push, pop or purge. `overflow` is high only in the cycle that follows that edge. The bench therefore drives each operation on a falling edge and lets exactly one rising edge pass. It drops the requests and reads `overflow` at the next falling edge, and only then walks `rdIdx` over the occupied slots to compare them with its own model of the queue.

// File: rtl/irq_queue_pkg.sv
`timescale 1ns/1ps
package irq_queue_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doPurge;
    logic refuse;
  } qStrobe_t;
endpackage

// File: rtl/irq_queue_ctrl.sv
`timescale 1ns/1ps
module irq_queue_ctrl
  import irq_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             purgeReq,
  input  logic [CNT_W-1:0] count,
  output qStrobe_t         strb,
  output logic             busy,
  output logic             overflow
);
  logic isEmpty, isFull;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_W'(DEPTH));

  always_comb begin
    busy         = purgeReq;
    strb.doPurge = purgeReq;
    strb.doPop   = popReq & ~purgeReq & ~isEmpty;
    strb.doPush  = pushValid & ~purgeReq & (~isFull | strb.doPop);
    strb.refuse  = pushValid & ~purgeReq & ~strb.doPush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else       overflow <= strb.refuse;
  end

  // R5
  full_push_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !popReq && !purgeReq && isFull) |=> overflow);
  // R5
  flag_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushValid) |=> !overflow);
  // R9
  stall_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (purgeReq) |=> !overflow);
endmodule

// File: rtl/irq_queue_data.sv
`timescale 1ns/1ps
module irq_queue_data
  import irq_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CLS_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  logic [CLS_W-1:0]  pushClass,
  input  logic [DATA_W-1:0] pushData,
  input  logic [CLS_W-1:0]  purgeLo,
  input  logic [CLS_W-1:0]  purgeHi,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  count,
  output logic              topValid,
  output logic [CLS_W-1:0]  topClass,
  output logic [DATA_W-1:0] topData,
  output logic [CLS_W-1:0]  rdClass,
  output logic [DATA_W-1:0] rdData
);
  logic [CLS_W-1:0]  clsQ  [DEPTH];
  logic [DATA_W-1:0] datQ  [DEPTH];
  logic [CLS_W-1:0]  nxtCls[DEPTH];
  logic [DATA_W-1:0] nxtDat[DEPTH];
  logic [CNT_W-1:0]  cntQ, cntNxt;
  logic [CNT_W-1:0]  startIdx, endIdx, removed, wrIdx;
  logic              endHit;
  logic [IDX_W-1:0]  topIdx;

  // purge range scan
  always_comb begin
    startIdx = cntQ;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (CNT_W'(i) < cntQ && clsQ[i] >= purgeLo) startIdx = CNT_W'(i);
    endHit = 1'b0;
    endIdx = '0;
    for (int j = 0; j < DEPTH; j++)
      if (CNT_W'(j) < cntQ && CNT_W'(j) >= startIdx && clsQ[j] <= purgeHi) begin
        endIdx = CNT_W'(j);
        endHit = 1'b1;
      end
    removed = endHit ? (endIdx - startIdx + CNT_W'(1)) : '0;
  end

  assign wrIdx = strb.doPop ? (cntQ - CNT_W'(1)) : cntQ;

  // next contents
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      nxtCls[k] = clsQ[k];
      nxtDat[k] = datQ[k];
    end
    if (strb.doPurge) begin
      for (int k = 0; k < DEPTH; k++)
        for (int s = 0; s < DEPTH; s++)
          if (removed != '0 && CNT_W'(k) >= startIdx &&
              SUM_W'(s) == SUM_W'(k) + SUM_W'(removed)) begin
            nxtCls[k] = clsQ[s];
            nxtDat[k] = datQ[s];
          end
    end else if (strb.doPush) begin
      for (int k = 0; k < DEPTH; k++)
        if (CNT_W'(k) == wrIdx) begin
          nxtCls[k] = pushClass;
          nxtDat[k] = pushData;
        end
    end
  end

  always_comb begin
    cntNxt = cntQ;
    if (strb.doPurge)                    cntNxt = cntQ - removed;
    else if (strb.doPush && !strb.doPop) cntNxt = cntQ + CNT_W'(1);
    else if (strb.doPop && !strb.doPush) cntNxt = cntQ - CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        clsQ[g] <= '0;
        datQ[g] <= '0;
      end else begin
        clsQ[g] <= nxtCls[g];
        datQ[g] <= nxtDat[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntNxt;
  end

  assign count    = cntQ;
  assign topValid = (cntQ != '0);
  assign topIdx   = IDX_W'(cntQ - CNT_W'(1));
  assign topClass = clsQ[topIdx];
  assign topData  = datQ[topIdx];
  assign rdClass  = clsQ[rdIdx];
  assign rdData   = datQ[rdIdx];

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doPush && !strb.doPop) |=> (count == $past(count) + CNT_W'(1)));
  // R4
  push_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush |=> (topData == $past(pushData) && topClass == $past(pushClass)));
  // R3
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doPop && !strb.doPush) |=> (count == $past(count) - CNT_W'(1)));
  // R8
  purge_no_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPurge |=> (count <= $past(count)));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/irq_class_queue.sv
`timescale 1ns/1ps
module irq_class_queue
  import irq_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CLS_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [CLS_W-1:0]  pushClass,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  input  logic              purgeReq,
  input  logic [CLS_W-1:0]  purgeLo,
  input  logic [CLS_W-1:0]  purgeHi,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  count,
  output logic              topValid,
  output logic [CLS_W-1:0]  topClass,
  output logic [DATA_W-1:0] topData,
  output logic [CLS_W-1:0]  rdClass,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              overflow
);
  qStrobe_t strb;

  irq_queue_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .purgeReq(purgeReq), .count(count), .strb(strb), .busy(busy),
    .overflow(overflow)
  );

  irq_queue_data #(.DEPTH(DEPTH), .CLS_W(CLS_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .pushClass(pushClass),
    .pushData(pushData), .purgeLo(purgeLo), .purgeHi(purgeHi), .rdIdx(rdIdx),
    .count(count), .topValid(topValid), .topClass(topClass), .topData(topData),
    .rdClass(rdClass), .rdData(rdData)
  );
endmodule

// File: tb/test_irq_class_queue.sv
`timescale 1ns/1ps
module test_irq_class_queue;
  localparam int DEPTH = 8, CLS_W = 4, DATA_W = 8;
  localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic pushValid = 0, popReq = 0, purgeReq = 0;
  logic [CLS_W-1:0] pushClass = '0, purgeLo = '0, purgeHi = '0;
  logic [DATA_W-1:0] pushData = '0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [CNT_W-1:0] count;
  logic topValid, busy, overflow;
  logic [CLS_W-1:0] topClass, rdClass;
  logic [DATA_W-1:0] topData, rdData;

  int checks = 0, fails = 0;
  bit done = 0;
  int mCls[$];
  int mDat[$];

  always #2 clk = ~clk;

  irq_class_queue #(.DEPTH(DEPTH), .CLS_W(CLS_W), .DATA_W(DATA_W)) i_irq_class_queue (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushClass(pushClass),
    .pushData(pushData), .popReq(popReq), .purgeReq(purgeReq), .purgeLo(purgeLo),
    .purgeHi(purgeHi), .rdIdx(rdIdx), .count(count), .topValid(topValid),
    .topClass(topClass), .topData(topData), .rdClass(rdClass), .rdData(rdData),
    .busy(busy), .overflow(overflow)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor side: compare design state to the model
  task automatic compareAll(string req, bit expOvf);
    chk(overflow == expOvf, {req, " overflow"}, int'(overflow), int'(expOvf));
    chk(int'(count) == mCls.size(), {req, " count"}, int'(count), mCls.size());
    chk(topValid == (mCls.size() != 0), "R3 topValid", int'(topValid), int'(mCls.size() != 0));
    if (mCls.size() != 0) begin
      chk(int'(topClass) == mCls[$], "R3 topClass", int'(topClass), mCls[$]);
      chk(int'(topData) == mDat[$], "R3 topData", int'(topData), mDat[$]);
    end
    for (int i = 0; i < mCls.size(); i++) begin
      rdIdx = IDX_W'(i);
      #0.2;
      chk(int'(rdClass) == mCls[i], {req, " R10 slot class"}, int'(rdClass), mCls[i]);
      chk(int'(rdData) == mDat[i], {req, " R10 slot data"}, int'(rdData), mDat[i]);
    end
  endtask

  // driver side: apply one operation, update the model, then compare
  task automatic step(string req, bit ps, int pc, int pd, bit pp, bit pg, int lo, int hi);
    bit expOvf;
    bit popOk;
    bit pushOk;
    int s;
    int e;
    @(negedge clk);
    pushValid = ps; pushClass = CLS_W'(pc); pushData = DATA_W'(pd);
    popReq = pp; purgeReq = pg; purgeLo = CLS_W'(lo); purgeHi = CLS_W'(hi);
    #0.5;
    chk(busy == pg, "R9 busy", int'(busy), int'(pg));
    expOvf = 0;
    if (pg) begin
      s = mCls.size();
      for (int i = 0; i < mCls.size(); i++) if (mCls[i] >= lo) begin s = i; break; end
      e = -1;
      for (int j = mCls.size() - 1; j >= s; j--) if (mCls[j] <= hi) begin e = j; break; end
      for (int k = e; k >= s; k--) begin mCls.delete(k); mDat.delete(k); end
    end else begin
      popOk = pp && mCls.size() > 0;
      pushOk = ps && (mCls.size() < DEPTH || popOk);
      if (popOk) begin void'(mCls.pop_back()); void'(mDat.pop_back()); end
      if (pushOk) begin mCls.push_back(pc); mDat.push_back(pd); end
      expOvf = ps && !pushOk;
    end
    @(negedge clk);
    pushValid = 0; popReq = 0; purgeReq = 0;
    compareAll(req, expOvf);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1", 0);

    // R2: fill with ascending classes
    step("R2", 1, 1, 8'hA0, 0, 0, 0, 0);
    step("R2", 1, 2, 8'hA1, 0, 0, 0, 0);
    step("R2", 1, 3, 8'hA2, 0, 0, 0, 0);
    step("R2", 1, 5, 8'hA3, 0, 0, 0, 0);
    step("R2", 1, 6, 8'hA4, 0, 0, 0, 0);
    step("R2", 1, 8, 8'hA5, 0, 0, 0, 0);
    step("R2", 1, 9, 8'hA6, 0, 0, 0, 0);
    step("R2", 1, 12, 8'hA7, 0, 0, 0, 0);
    // R5: full push refused, then flag clears
    step("R5", 1, 14, 8'hEE, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0);
    // R4: replace top on a full queue
    step("R4", 1, 13, 8'hB0, 1, 0, 0, 0);
    // R3: pop
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    // R6 R7 R8: purge a middle run, classes 3..8
    step("R8", 0, 0, 0, 0, 1, 3, 8);
    // R9: push and pop stalled by a purge with an empty range
    step("R9", 1, 7, 8'hC0, 1, 1, 15, 15);
    // R7: start found but no end candidate at or above it
    step("R7", 0, 0, 0, 0, 1, 2, 1);
    // R6: no class reaches the low bound
    step("R6", 0, 0, 0, 0, 1, 15, 15);
    step("R2", 1, 4, 8'hC1, 0, 0, 0, 0);
    step("R2", 1, 10, 8'hC2, 0, 0, 0, 0);
    // R8: purge from the bottom, classes 0..4
    step("R8", 0, 0, 0, 0, 1, 0, 4);
    // R8: purge through the top
    step("R8", 0, 0, 0, 0, 1, 9, 15);
    // R3: drain and pop on empty
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    // R4: push and pop on empty behaves as a push
    step("R4", 1, 6, 8'hD0, 1, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule